// File: doc/BRIEF.md
# PHY Power-Up Calibration Sequencer

This block is a hardware state machine that brings the analog front end of a storage-interface PHY up or down without software polling. A single request pulse selects power-on or power-off. A power-off request clears the analog enables and reports completion on the next cycle.

A power-on request does more work. At acceptance it programs the drive-strength code and the output tap delay, and it clears the power and DLL enables. After a settle interval it raises power, then waits for the calibration handshake. Only when calibration reports done does it load the frequency class and enable the DLL. If a card clock is present, it then waits for the DLL-ready handshake. Each wait has its own timeout. All intervals are counted in cycles of a fixed reference clock.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, `pwr_up`, `dll_en`, `tap_en`, `busy` and `done` are low, and `freq_sel`, `drv_sel`, `tap_val` and `err` are zero.
- R2: On the edge that accepts a power-on request, `drv_sel` takes `drv_code`, `tap_en` goes high and `tap_val` becomes 4. These hold until the next accepted power-on request.
- R3: Every accepted request drives `pwr_up` and `dll_en` low on the accepting edge. For a power-off request, `done` is high in the very next cycle with `err` equal to 0.
- R4: `pwr_up` rises exactly `SETTLE_CYC` clock edges after the accepting edge.
- R5: If `cal_done` is not sampled high within `CAL_TMO_CYC` edges after `pwr_up` rises, the sequence ends with `err` = 1 and `dll_en` stays low. A `cal_done` sampled on the last allowed edge still counts as success.
- R6: `freq_sel` keeps its old value until the edge that samples `cal_done` high, and takes the latched frequency class there. `dll_en` rises on the following edge.
- R7: If `clk_present` was low at acceptance, `done` is high with `err` = 0 in the same cycle that `dll_en` first reads high, and `dll_ready` is not waited for.
- R8: Otherwise, `dll_ready` sampled high within `DLL_TMO_CYC` edges after `dll_en` rises ends the sequence with `err` = 0. Without it, the sequence ends with `err` = 2.
- R9: `busy` is high from the accepting edge until `done` has been shown. A request seen while `busy` is high is ignored.
- R10: `done` is high for exactly one cycle per accepted request. `err` holds its code until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request pulse, taken only when idle |
| req_on | input | 1 | 1 = power on, 0 = power off |
| freq_class | input | 2 | DLL frequency range code, passed to `freq_sel` after calibration |
| drv_code | input | 3 | Drive-strength code applied on power-on |
| clk_present | input | 1 | High when the card clock runs; low skips the lock wait |
| cal_done | input | 1 | Calibration finished, from the analog side |
| dll_ready | input | 1 | DLL locked, from the analog side |
| pwr_up | output | 1 | Analog power enable |
| dll_en | output | 1 | DLL enable |
| freq_sel | output | 2 | DLL frequency range select |
| drv_sel | output | 3 | Drive-strength select |
| tap_en | output | 1 | Output tap delay enable |
| tap_val | output | 4 | Output tap delay value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 calibration timeout, 2 DLL timeout |

## Verification
The analog side is a bench model whose calibration and lock latencies can be set per run. The runs cover:
- A normal power-on with a running clock, which separates the lock wait from the no-clock shortcut.
- Calibration arriving on the last allowed edge and one edge later, which pins down the exact timeout boundary.
- A missing lock, which must give the DLL timeout code and not the calibration one.
- Power-off requests and requests sent while busy, which show that only idle requests are taken and that both enables drop at once.

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter int unsigned SETTLE_CYC  = 300,
  parameter int unsigned CAL_TMO_CYC = 5000,
  parameter int unsigned DLL_TMO_CYC = 5000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_on,
  input  logic [1:0] freq_class,
  input  logic [2:0] drv_code,
  input  logic       clk_present,
  input  logic       cal_done,
  input  logic       dll_ready,
  output logic       pwr_up,
  output logic       dll_en,
  output logic [1:0] freq_sel,
  output logic [2:0] drv_sel,
  output logic       tap_en,
  output logic [3:0] tap_val,
  output logic       busy,
  output logic       done,
  output logic [1:0] err
);
  localparam int unsigned MAX_A = (SETTLE_CYC > CAL_TMO_CYC) ? SETTLE_CYC : CAL_TMO_CYC;
  localparam int unsigned MAX_C = (MAX_A > DLL_TMO_CYC) ? MAX_A : DLL_TMO_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] CAL_LAST = CNT_W'(CAL_TMO_CYC - 1);
  localparam logic [CNT_W-1:0] DLL_LAST = CNT_W'(DLL_TMO_CYC - 1);
  localparam logic [3:0] TAP_DEFAULT = 4'd4;

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_CAL, S_DLL_ON, S_LOCK, S_FIN} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       freq_q;
  logic             clk_q;

  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      freq_q   <= '0;
      clk_q    <= 1'b0;
      pwr_up   <= 1'b0;
      dll_en   <= 1'b0;
      freq_sel <= '0;
      drv_sel  <= '0;
      tap_en   <= 1'b0;
      tap_val  <= '0;
      err      <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          pwr_up <= 1'b0;
          dll_en <= 1'b0;
          err    <= 2'd0;
          cnt    <= '0;
          if (req_on) begin
            drv_sel <= drv_code;
            tap_en  <= 1'b1;
            tap_val <= TAP_DEFAULT;
            freq_q  <= freq_class;
            clk_q   <= clk_present;
            st      <= S_SETTLE;
          end else begin
            st <= S_FIN;
          end
        end
        S_SETTLE: if (cnt == SET_LAST) begin
          pwr_up <= 1'b1;
          cnt    <= '0;
          st     <= S_CAL;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_CAL: if (cal_done) begin
          freq_sel <= freq_q;
          st       <= S_DLL_ON;
        end else if (cnt == CAL_LAST) begin
          err <= 2'd1;
          st  <= S_FIN;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_DLL_ON: begin
          dll_en <= 1'b1;
          cnt    <= '0;
          st     <= clk_q ? S_LOCK : S_FIN;
        end
        S_LOCK: if (dll_ready) begin
          st <= S_FIN;
        end else if (cnt == DLL_LAST) begin
          err <= 2'd2;
          st  <= S_FIN;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module phy_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_up,
  input logic       dll_en,
  input logic       busy,
  input logic       done,
  input logic [1:0] err
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  a_r6_dll_after_power: assert property (@(posedge clk) disable iff (!rst_n) $rose(dll_en) |-> pwr_up);
  a_r4_power_before_dll: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwr_up) |-> !dll_en);
  a_r5_cal_err_no_dll: assert property (@(posedge clk) disable iff (!rst_n) (done && err == 2'd1) |-> !dll_en);
  a_r10_err_code_range: assert property (@(posedge clk) disable iff (!rst_n) done |-> err != 2'd3);
endmodule

bind phy_pwr_seq phy_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .dll_en(dll_en),
  .busy(busy), .done(done), .err(err)
);

// File: tb/phy_pwr_seq_bench.sv
module phy_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S  = 4;
  localparam int CT = 12;
  localparam int DT = 20;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_on = 0, clk_present = 0;
  logic [1:0] freq_class = 0;
  logic [2:0] drv_code = 0;
  logic cal_done = 0, dll_ready = 0;
  logic pwr_up, dll_en, tap_en, busy, done;
  logic [1:0] freq_sel, err;
  logic [2:0] drv_sel;
  logic [3:0] tap_val;

  int compared = 0, mismatched = 0;
  int cal_lat = 3, dll_lat = 5;
  int hc_p = 0, hc_d = 0;

  phy_pwr_seq #(.SETTLE_CYC(S), .CAL_TMO_CYC(CT), .DLL_TMO_CYC(DT)) u_phy_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
    .freq_class(freq_class), .drv_code(drv_code), .clk_present(clk_present),
    .cal_done(cal_done), .dll_ready(dll_ready), .pwr_up(pwr_up), .dll_en(dll_en),
    .freq_sel(freq_sel), .drv_sel(drv_sel), .tap_en(tap_en), .tap_val(tap_val),
    .busy(busy), .done(done), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  // analog side model
  always @(negedge clk) begin
    hc_p = pwr_up ? hc_p + 1 : 0;
    hc_d = (dll_en && clk_present) ? hc_d + 1 : 0;
    cal_done  <= pwr_up && hc_p >= cal_lat;
    dll_ready <= dll_en && clk_present && hc_d >= dll_lat;
  end

  // reference model: phase 0 idle,1 settle,2 cal,3 dll on,4 lock,5 finish
  int ph = 0, k = 0;
  logic m_pwr = 0, m_dll = 0, m_ten = 0, m_ck = 0;
  logic [1:0] m_fq = 0, m_fl = 0, m_err = 0;
  logic [2:0] m_drv = 0;
  logic [3:0] m_tap = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; k = 0; m_pwr = 0; m_dll = 0; m_ten = 0; m_fq = 0; m_err = 0; m_drv = 0; m_tap = 0;
    end else begin
      case (ph)
        0: if (req_valid) begin
             m_pwr = 0; m_dll = 0; m_err = 0; k = 0;
             if (req_on) begin
               m_drv = drv_code; m_ten = 1; m_tap = 4; m_fl = freq_class; m_ck = clk_present; ph = 1;
             end else ph = 5;
           end
        1: begin k++; if (k == S) begin m_pwr = 1; k = 0; ph = 2; end end
        2: begin k++; if (cal_done) begin m_fq = m_fl; ph = 3; end
                  else if (k == CT) begin m_err = 1; ph = 5; end end
        3: begin m_dll = 1; k = 0; ph = m_ck ? 4 : 5; end
        4: begin k++; if (dll_ready) ph = 5; else if (k == DT) begin m_err = 2; ph = 5; end end
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 drv_sel", drv_sel, m_drv);
    chk("R2 tap_en", tap_en, m_ten);
    chk("R2 tap_val", tap_val, m_tap);
    chk("R4 pwr_up", pwr_up, m_pwr);
    chk("R6 dll_en", dll_en, m_dll);
    chk("R6 freq_sel", freq_sel, m_fq);
    chk("R9 busy", busy, ph != 0);
    chk("R10 done", done, ph == 5);
    chk("R5/R8 err", err, m_err);
  end

  task automatic request(input logic on, input logic [1:0] fq, input logic [2:0] dc, input logic ck);
    @(negedge clk);
    req_valid = 1; req_on = on; freq_class = fq; drv_code = dc; clk_present = ck;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output int e);
    while (!done) @(negedge clk);
    e = err;
    @(negedge clk);
  endtask

  task automatic run;
    int e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pwr_up", pwr_up, 0); chk("R1 dll_en", dll_en, 0); chk("R1 busy", busy, 0);
    chk("R1 done", done, 0); chk("R1 err", err, 0); chk("R1 tap_en", tap_en, 0);
    rst_n = 1;
    // normal power-on with clock, lock wait (R8)
    cal_lat = 3; dll_lat = 5;
    request(1, 2'd2, 3'd3, 1);
    chk("R2 tap_val after accept", tap_val, 4);
    wait_done(e); chk("R8 success", e, 0);
    // R3 power-off
    request(0, 2'd0, 3'd0, 1);
    chk("R3 done next cycle", done, 1);
    chk("R3 pwr_up low", pwr_up, 0);
    wait_done(e); chk("R3 err", e, 0);
    // R9 request while busy ignored
    request(1, 2'd1, 3'd5, 1);
    repeat (2) @(negedge clk);
    req_valid = 1; req_on = 0; @(negedge clk); req_valid = 0;
    chk("R9 ignored, power stays", busy, 1);
    wait_done(e); chk("R9 sequence completes", e, 0);
    chk("R9 dll_en kept", dll_en, 1);
    // R5 boundary: cal on last allowed edge
    cal_lat = CT;
    request(1, 2'd3, 3'd1, 1);
    wait_done(e); chk("R5 boundary success", e, 0);
    // R5 timeout
    cal_lat = CT + 1;
    request(1, 2'd0, 3'd2, 1);
    wait_done(e); chk("R5 cal timeout", e, 1);
    chk("R5 dll_en low", dll_en, 0);
    // R8 DLL timeout
    cal_lat = 2; dll_lat = DT + 1;
    request(1, 2'd1, 3'd4, 1);
    wait_done(e); chk("R8 dll timeout", e, 2);
    // R7 no clock
    dll_lat = 1;
    request(1, 2'd2, 3'd6, 0);
    while (!dll_en) @(negedge clk);
    chk("R7 done with dll_en", done, 1);
    chk("R7 err", err, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run;
      begin
        repeat (20000) @(posedge clk);
        mismatched++; compared++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule